// File: doc/BRIEF.md
# Two-phase sixteen-bit register machine

A small complete processor: sixteen general registers of 16 bits, a unified 256-word by 16-bit memory, an 8-bit program counter and an instruction register. Every instruction takes exactly two clock cycles. In the first cycle the word at the program counter is latched into the instruction register and the counter advances. In the second cycle the operation runs and its result is written back. There is no pipelining, no interrupt and no external bus.

The memory lives inside the core. A load port fills it before the program runs, normally while reset is held. The highest memory address is not storage. A read of that address returns the word on `in_data` and pulses `in_take`. A write to it presents the word on `out_data` with a one-cycle `out_valid`. The halt instruction stops the core, and `halted` stays high until reset. `exec_phase` shows which of the two cycles the core is in.

Top module: `phase2_cpu`

## Requirements
- R1: While reset is asserted (`rst_n` low, asynchronous), `halted`, `out_valid`, `in_take` and `exec_phase` are 0, and the program counter is 0. The first instruction after reset is fetched from address 0, and its fetch cycle is the first clock edge after release.
- R2: Fetch and execute alternate strictly while not halted. `exec_phase` is 1 during an execute cycle, so instruction k after reset executes on clock edge 2k+2.
- R3: Instruction word layout: opcode in [15:12] and d in [11:8]. The register form has s in [7:4] and t in [3:0]; the address form has addr in [7:0]. Opcodes 1 to 6 write R[d] with R[s]+R[t], R[s]-R[t], R[s]&R[t], R[s]^R[t], R[s]<<R[t] and R[s]>>R[t] (logical), all modulo 2^16. For example, R3=0028 and R4=0064 with word 1234 give R2=008C.
- R4: Register 0 always reads as zero, and any write to it is discarded.
- R5: Opcode 7 writes addr, zero-extended, to R[d]. Opcode 8 writes mem[addr] to R[d]. Opcode 9 writes R[d] to mem[addr].
- R6: Opcode A writes mem[R[t][7:0]] to R[d]. Opcode B writes R[d] to mem[R[t][7:0]].
- R7: Opcode C sets pc to addr when R[d] is zero. Opcode D sets pc to addr when R[d] is positive as a signed two's-complement value. Otherwise execution falls through.
- R8: Opcode E sets pc to R[t][7:0]. Opcode F writes the already-incremented pc, zero-extended, to R[d] and sets pc to addr, both in the same execute cycle.
- R9: A load from address FF, direct or indirect, returns `in_data` and raises `in_take` for that execute cycle only. A store to FF leaves memory alone and raises `out_valid` for the single cycle after the execute edge, with `out_data` equal to R[d].
- R10: Opcode 0 sets `halted`, which then holds until reset. After that the core makes no further output, input or state change.
- R11: A cycle with `load_en` high writes `load_data` into the memory word at `load_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Memory preload write strobe |
| load_addr | input | 8 | Preload word address |
| load_data | input | 16 | Preload word |
| in_data | input | 16 | Word returned by a read of address FF |
| in_take | output | 1 | High in the execute cycle that consumes `in_data` |
| out_valid | output | 1 | One-cycle strobe for a write to address FF |
| out_data | output | 16 | Word written to address FF |
| exec_phase | output | 1 | 1 during an execute cycle, 0 during a fetch cycle |
| halted | output | 1 | Halt instruction executed |

## Verification
Jump-and-link is where two functions share one execute edge. On that edge the link value is written to a register and the program counter is redirected. A test program calls a subroutine that stores the link register to the output word and later returns through it with a jump-register. A wrong link value, or a link written after the redirect, shows up as a wrong output word or a lost return. The same program puts a taken and a not-taken branch in front of stores to the output word, so the scoreboard's queue of expected words also judges the control flow.

// File: rtl/phase2_cpu.sv
module phase2_cpu #(
  parameter int DW = 16,
  parameter int AW = 8,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] load_addr,
  input  logic [DW-1:0] load_data,
  input  logic [DW-1:0] in_data,
  output logic          in_take,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          exec_phase,
  output logic          halted
);
  localparam int NR = 1 << RW;
  localparam int NM = 1 << AW;
  localparam logic [AW-1:0] IO_ADDR = {AW{1'b1}};

  logic [DW-1:0] mem [NM];
  logic [DW-1:0] rf  [NR];
  logic [AW-1:0] pc;
  logic [DW-1:0] ir;

  wire [3:0]    op   = ir[DW-1 -: 4];
  wire [RW-1:0] fd   = ir[DW-5 -: RW];
  wire [RW-1:0] fs   = ir[DW-5-RW -: RW];
  wire [RW-1:0] ft   = ir[RW-1:0];
  wire [AW-1:0] addr = ir[AW-1:0];

  wire [DW-1:0] vd = (fd == '0) ? '0 : rf[fd];
  wire [DW-1:0] vs = (fs == '0) ? '0 : rf[fs];
  wire [DW-1:0] vt = (ft == '0) ? '0 : rf[ft];

  wire          indirect = (op == 4'hA) || (op == 4'hB);
  wire [AW-1:0] ea       = indirect ? vt[AW-1:0] : addr;
  wire          ea_io    = (ea == IO_ADDR);
  wire [DW-1:0] rd_word  = ea_io ? in_data : mem[ea];
  wire          exe      = exec_phase && !halted;

  logic          wb_en, st_en, jump;
  logic [DW-1:0] wb_val;
  logic [AW-1:0] target;

  always_comb begin
    wb_en  = 1'b0;
    wb_val = '0;
    st_en  = 1'b0;
    jump   = 1'b0;
    target = addr;
    case (op)
      4'h1: begin wb_en = 1'b1; wb_val = vs + vt;  end
      4'h2: begin wb_en = 1'b1; wb_val = vs - vt;  end
      4'h3: begin wb_en = 1'b1; wb_val = vs & vt;  end
      4'h4: begin wb_en = 1'b1; wb_val = vs ^ vt;  end
      4'h5: begin wb_en = 1'b1; wb_val = vs << vt; end
      4'h6: begin wb_en = 1'b1; wb_val = vs >> vt; end
      4'h7: begin wb_en = 1'b1; wb_val = {{(DW-AW){1'b0}}, addr}; end
      4'h8, 4'hA: begin wb_en = 1'b1; wb_val = rd_word; end
      4'h9, 4'hB: st_en = 1'b1;
      4'hC: jump = (vd == '0);
      4'hD: jump = !vd[DW-1] && (vd != '0);
      4'hE: begin jump = 1'b1; target = vt[AW-1:0]; end
      4'hF: begin wb_en = 1'b1; wb_val = {{(DW-AW){1'b0}}, pc}; jump = 1'b1; end
      default: ;
    endcase
  end

  assign in_take = exe && ((op == 4'h8) || (op == 4'hA)) && ea_io;

  always_ff @(posedge clk) begin
    if (load_en)
      mem[load_addr] <= load_data;
    else if (exe && st_en && !ea_io)
      mem[ea] <= vd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) rf[i] <= '0;
    end else if (exe && wb_en && fd != '0) begin
      rf[fd] <= wb_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc         <= '0;
      ir         <= '0;
      exec_phase <= 1'b0;
      halted     <= 1'b0;
      out_valid  <= 1'b0;
      out_data   <= '0;
    end else begin
      out_valid <= 1'b0;
      if (!halted) begin
        if (!exec_phase) begin
          ir         <= mem[pc];
          pc         <= pc + 1'b1;
          exec_phase <= 1'b1;
        end else begin
          exec_phase <= 1'b0;
          if (op == 4'h0) halted <= 1'b1;
          if (jump) pc <= target;
          if (st_en && ea_io) begin
            out_valid <= 1'b1;
            out_data  <= vd;
          end
        end
      end
    end
  end
endmodule

// File: rtl/phase2_cpu_chk.sv
module phase2_cpu_chk (
  input logic clk,
  input logic rst_n,
  input logic exec_phase,
  input logic halted,
  input logic out_valid,
  input logic in_take
);
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (!exec_phase && !halted && !out_valid && !in_take));

  p_alternate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |=> (halted || exec_phase != $past(exec_phase)));

  p_out_after_exec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!exec_phase && $past(exec_phase)));

  p_take_in_exec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_take |-> exec_phase);

  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!out_valid && !in_take));

  p_halt_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && $past(halted)) |-> $stable(exec_phase));
endmodule

bind phase2_cpu phase2_cpu_chk u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .exec_phase(exec_phase),
  .halted(halted),
  .out_valid(out_valid),
  .in_take(in_take)
);

// File: tb/phase2_cpu_tb.sv
module phase2_cpu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic [7:0]  load_addr = '0;
  logic [15:0] load_data = '0;
  logic [15:0] in_data = '0;
  logic        in_take, out_valid, exec_phase, halted;
  logic [15:0] out_data;

  phase2_cpu u_dut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .in_data(in_data), .in_take(in_take),
    .out_valid(out_valid), .out_data(out_data), .exec_phase(exec_phase),
    .halted(halted)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] img [256];
  logic [15:0] exp_q [$];
  string       tag_q [$];
  int cyc = 0;
  int first_out = -1;
  int take_cyc = -1;
  int take_cnt = 0;
  int exec_seen2 = -1;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic expect_out(input logic [15:0] w, input string req);
    exp_q.push_back(w);
    tag_q.push_back(req);
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; first_out = -1; take_cyc = -1; take_cnt = 0; exec_seen2 = -1;
    end else begin
      cyc++;
      if (cyc == 2) exec_seen2 = exec_phase;
      if (in_take) begin
        take_cnt++;
        if (take_cyc < 0) take_cyc = cyc;
      end
      if (out_valid) begin
        if (first_out < 0) first_out = cyc;
        if (exp_q.size() == 0) begin
          chk(0, "R9/R10 unexpected output", out_data, 0);
        end else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(out_data === e, t, out_data, e);
        end
      end
    end
  end

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = 16'h0000;
  endtask

  task automatic run_prog(input string name);
    @(posedge clk); #1;
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) begin
      load_en = 1'b1; load_addr = i[7:0]; load_data = img[i];
      @(posedge clk); #1;
    end
    load_en = 1'b0;
    @(negedge clk);
    chk(halted == 1'b0 && out_valid == 1'b0 && exec_phase == 1'b0 && in_take == 1'b0,
        "R1 reset outputs", {halted, out_valid, exec_phase, in_take}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    begin
      int w = 0;
      while (!halted && w < 3000) begin
        @(negedge clk);
        w++;
      end
      chk(halted == 1'b1, {"R10 halt reached ", name}, halted, 1);
    end
    repeat (20) @(negedge clk);
    chk(halted == 1'b1, "R10 halted holds", halted, 1);
    chk(exp_q.size() == 0, {"R9 all outputs seen ", name}, exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    // Program 1: ALU, register 0, first-output timing
    clear_img();
    img[8'h00] = 16'h7328; img[8'h01] = 16'h7464; img[8'h02] = 16'h1234;
    img[8'h03] = 16'h92FF; img[8'h04] = 16'h2534; img[8'h05] = 16'h95FF;
    img[8'h06] = 16'h3534; img[8'h07] = 16'h95FF; img[8'h08] = 16'h4534;
    img[8'h09] = 16'h95FF; img[8'h0A] = 16'h7603; img[8'h0B] = 16'h5536;
    img[8'h0C] = 16'h95FF; img[8'h0D] = 16'h6546; img[8'h0E] = 16'h95FF;
    img[8'h0F] = 16'h7077; img[8'h10] = 16'h1203; img[8'h11] = 16'h92FF;
    img[8'h12] = 16'h90FF; img[8'h13] = 16'h0000;
    expect_out(16'h008C, "R3 add example");
    expect_out(16'hFFC4, "R3 sub wrap");
    expect_out(16'h0020, "R3 and");
    expect_out(16'h004C, "R3 xor");
    expect_out(16'h0140, "R3 shl");
    expect_out(16'h000C, "R3 shr");
    expect_out(16'h0028, "R4 r0 write discarded");
    expect_out(16'h0000, "R4 r0 reads zero");
    run_prog("alu");
    chk(first_out == 9, "R2 first output cycle", first_out, 9);
    chk(exec_seen2 == 1, "R1 fetch starts at release", exec_seen2, 1);

    // Program 2: memory, indirect, I/O word
    clear_img();
    img[8'h00] = 16'h8840; img[8'h01] = 16'h9842; img[8'h02] = 16'h8A42;
    img[8'h03] = 16'h9AFF; img[8'h04] = 16'h7B41; img[8'h05] = 16'hAC0B;
    img[8'h06] = 16'h9CFF; img[8'h07] = 16'h7B43; img[8'h08] = 16'hBC0B;
    img[8'h09] = 16'h8D43; img[8'h0A] = 16'h9DFF; img[8'h0B] = 16'h8EFF;
    img[8'h0C] = 16'h9EFF; img[8'h0D] = 16'h7BFF; img[8'h0E] = 16'hBE0B;
    img[8'h0F] = 16'h0000;
    img[8'h40] = 16'hBEEF; img[8'h41] = 16'h1357;
    in_data = 16'hA5A5;
    expect_out(16'hBEEF, "R5 R11 load/store direct");
    expect_out(16'h1357, "R6 load indirect");
    expect_out(16'h1357, "R6 store indirect");
    expect_out(16'hA5A5, "R9 input read");
    expect_out(16'hA5A5, "R9 indirect store to io");
    run_prog("mem");
    chk(take_cnt == 1, "R9 in_take count", take_cnt, 1);
    chk(take_cyc == 24, "R9 in_take cycle", take_cyc, 24);

    // Program 3: branches, jump register, jump-and-link
    clear_img();
    img[8'h00] = 16'h7100; img[8'h01] = 16'hC105; img[8'h02] = 16'h71EE;
    img[8'h03] = 16'h91FF; img[8'h04] = 16'h0000; img[8'h05] = 16'h7301;
    img[8'h06] = 16'h2203; img[8'h07] = 16'hD20A; img[8'h08] = 16'h92FF;
    img[8'h09] = 16'hD30B; img[8'h0A] = 16'h0000; img[8'h0B] = 16'hC30A;
    img[8'h0C] = 16'hF520; img[8'h0D] = 16'h0000;
    img[8'h20] = 16'h95FF; img[8'h21] = 16'h7630; img[8'h22] = 16'hE006;
    img[8'h30] = 16'h7777; img[8'h31] = 16'h97FF; img[8'h32] = 16'hE005;
    expect_out(16'hFFFF, "R7 branch zero taken, positive not taken on negative");
    expect_out(16'h000D, "R8 link value");
    expect_out(16'h0077, "R8 jump register");
    run_prog("flow");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #700000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R10 run did not end actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule